// File: doc/BRIEF.md
# Serial-programmed attenuator state controller

This block is the digital control for two independent step-attenuator paths, each paired with an analog-attenuator DAC. A host writes one 56-bit word over a three-wire serial link made of clock, data and an active-low chip-select. The word carries one 8-bit DAC code and four 5-bit attenuation presets for each path. The word takes effect only when chip-select returns high after exactly 56 bits.

Each path has two fast select pins that pick one of its four stored presets. No serial traffic is needed for that choice. A digital-mode pin can instead route a raw 5-bit parallel word per path to the attenuator. An analog-mode pin decides whether each path's DAC is enabled and fed its stored code.

The serial pins are asynchronous to the system clock. They pass through multi-stage synchronisers, and their edges are detected in the system clock domain.

Top module: `atten_state_ctrl`

## Requirements
- R1: After reset, all eight presets and both DAC codes read as zero. With digital mode 1 and analog mode 1, att_code is 0 and dac_code is 0 for both paths, and dac_en is 2'b11.
- R2: A frame is shifted in most-significant bit first. One bit is taken on each rising serial clock while chip-select is low, so the first bit sent lands in frame bit 55. Serial clock edges while chip-select is high shift nothing.
- R3: A rising chip-select after exactly 56 bits copies the frame into the holding registers. The outputs show the new values after the third rising system clock edge that follows the pin going high, and not after the second.
- R4: Path 1 fields: frame bits 7:0 are its DAC code (bit 7 MSB), 12:8 preset 1, 17:13 preset 2, 22:18 preset 3 and 27:23 preset 4.
- R5: Path 2 fields: frame bits 35:28 are its DAC code, 40:36 preset 1, 45:41 preset 2, 50:46 preset 3 and 55:51 preset 4. Within each 5-bit word the bits weigh 16, 8, 4, 2 and 1 dB from MSB down.
- R6: With digital mode 1, a path's att_code is the preset picked by its pins (sel_b, sel_a): 00 selects preset 1, 01 preset 2, 10 preset 3 and 11 preset 4. Each path follows only its own pins, and the output follows a pin change with no serial traffic.
- R7: With digital mode 0, each path's att_code equals its own 5-bit slice of par_code (path 1 in bits 4:0, path 2 in bits 9:5), whatever is stored.
- R8: With analog mode 1, dac_en is 1 and dac_code carries the stored code (path 1 in bits 7:0, path 2 in bits 15:8). With analog mode 0, dac_en is 0 and dac_code is 0.
- R9: A chip-select rise after any bit count other than 56 (for example 55 or 57) leaves all presets and DAC codes unchanged.
- R10: Frames are received correctly when the system clock runs at four times the serial clock, meaning each serial half-period lasts two system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_csn | input | 1 | Active-low frame select; rising edge commits |
| dig_mode | input | 1 | 1: attenuation from presets; 0: from par_code |
| ana_mode | input | 1 | 1: DAC enabled with stored code; 0: DAC off |
| par_code | input | NUM_PATHS*WORD_W | Direct attenuation words, path p at [p*WORD_W +: WORD_W] |
| sel_a | input | NUM_PATHS | Preset select low bit, one per path |
| sel_b | input | NUM_PATHS | Preset select high bit, one per path |
| att_code | output | NUM_PATHS*WORD_W | Final attenuation code per path |
| dac_code | output | NUM_PATHS*DAC_W | DAC code per path |
| dac_en | output | NUM_PATHS | DAC enable per path |

## Verification
A frame commit and a change on the preset-select pins can land in the same system clock cycle. In that case the output must show the new preset table indexed by the new select value, with no mix of old table and new select. The bench provokes this case by driving new select values at the same instant chip-select is raised. It then judges att_code against its model both in the cycle before the commit and in the cycle the commit lands. Random frames of 55, 56 and 57 bits sent at several serial rates are mixed in, so the length gate is also exercised.

// File: rtl/sctl_pkg.sv
`timescale 1ns/1ps
package sctl_pkg;

   // Source of a path's attenuation word
   typedef enum logic {
      SRC_PARALLEL = 1'b0,
      SRC_PRESET   = 1'b1
   } src_e;

   // Who drives the analog attenuator
   typedef enum logic {
      ANA_EXTERNAL = 1'b0,
      ANA_DAC      = 1'b1
   } ana_e;

endpackage

// File: rtl/sctl_sync.sv
`timescale 1ns/1ps
module sctl_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sctl_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/sctl_frame.sv
`timescale 1ns/1ps
module sctl_frame #(
   parameter int FRAME_W = 56,
   localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_q,
   input  logic               dat_q,
   input  logic               csn_q,
   output logic               csn_hi,
   output logic [FRAME_W-1:0] shreg,
   output logic [CNT_W-1:0]   cnt,
   output logic               commit,
   output logic [FRAME_W-1:0] hold
);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("sctl_frame: FRAME_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

   logic sclk_prev, csn_prev;
   logic sclk_rise, csn_rise;

   assign sclk_rise = sclk_q & ~sclk_prev;
   assign csn_rise  = csn_q  & ~csn_prev;
   assign commit    = csn_rise && (cnt == CNT_FULL);
   assign csn_hi    = csn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         csn_prev  <= 1'b1;
      end else begin
         sclk_prev <= sclk_q;
         csn_prev  <= csn_q;
      end
   end

   // shift register and saturating bit counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (csn_q) begin
         cnt <= '0;
      end else if (sclk_rise) begin
         shreg <= {shreg[FRAME_W-2:0], dat_q};
         if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold <= '0;
      else if (commit) hold <= shreg;
   end

endmodule

// File: rtl/sctl_path.sv
`timescale 1ns/1ps
module sctl_path
   import sctl_pkg::*;
#(
   parameter int WORD_W      = 5,
   parameter int DAC_W       = 8,
   parameter int NUM_PRESETS = 4,
   localparam int SEL_W      = $clog2(NUM_PRESETS),
   localparam int SEG_W      = DAC_W + NUM_PRESETS * WORD_W
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [WORD_W-1:0] par,
   input  logic [SEL_W-1:0]  sel,
   input  logic              dig_mode,
   input  logic              ana_mode,
   output logic [WORD_W-1:0] att,
   output logic [DAC_W-1:0]  dac,
   output logic              dac_en
);

   logic [WORD_W-1:0] preset [NUM_PRESETS];

   for (genvar k = 0; k < NUM_PRESETS; k++) begin : g_preset
      assign preset[k] = seg[DAC_W + k*WORD_W +: WORD_W];
   end

   always_comb begin
      if (src_e'(dig_mode) == SRC_PRESET) att = preset[sel];
      else                                att = par;
   end

   assign dac_en = (ana_e'(ana_mode) == ANA_DAC);
   assign dac    = dac_en ? seg[DAC_W-1:0] : '0;

endmodule

// File: rtl/atten_state_ctrl.sv
`timescale 1ns/1ps
module atten_state_ctrl #(
   parameter int NUM_PATHS   = 2,
   parameter int WORD_W      = 5,
   parameter int DAC_W       = 8,
   parameter int NUM_PRESETS = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ser_clk,
   input  logic                        ser_dat,
   input  logic                        ser_csn,
   input  logic                        dig_mode,
   input  logic                        ana_mode,
   input  logic [NUM_PATHS*WORD_W-1:0] par_code,
   input  logic [NUM_PATHS-1:0]        sel_a,
   input  logic [NUM_PATHS-1:0]        sel_b,
   output logic [NUM_PATHS*WORD_W-1:0] att_code,
   output logic [NUM_PATHS*DAC_W-1:0]  dac_code,
   output logic [NUM_PATHS-1:0]        dac_en
);

   localparam int SEG_W   = DAC_W + NUM_PRESETS * WORD_W;
   localparam int FRAME_W = NUM_PATHS * SEG_W;
   localparam int CNT_W   = $clog2(FRAME_W + 2);

   if (NUM_PRESETS != 4) begin : g_bad_presets
      $error("atten_state_ctrl: two select pins address exactly 4 presets");
   end
   if (NUM_PATHS < 1 || WORD_W < 1 || DAC_W < 1) begin : g_bad_widths
      $error("atten_state_ctrl: widths and path count must be positive");
   end

   logic [2:0]         pin_q;
   logic               csn_hi;
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   bit_cnt;
   logic               commit;
   logic [FRAME_W-1:0] hold_q;

   // {csn, data, clock}; chip-select idles high
   sctl_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_csn, ser_dat, ser_clk}),
      .q     (pin_q)
   );

   sctl_frame #(
      .FRAME_W (FRAME_W)
   ) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_q (pin_q[0]),
      .dat_q  (pin_q[1]),
      .csn_q  (pin_q[2]),
      .csn_hi (csn_hi),
      .shreg  (shreg),
      .cnt    (bit_cnt),
      .commit (commit),
      .hold   (hold_q)
   );

   for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
      sctl_path #(
         .WORD_W      (WORD_W),
         .DAC_W       (DAC_W),
         .NUM_PRESETS (NUM_PRESETS)
      ) u_path (
         .seg      (hold_q[p*SEG_W +: SEG_W]),
         .par      (par_code[p*WORD_W +: WORD_W]),
         .sel      ({sel_b[p], sel_a[p]}),
         .dig_mode (dig_mode),
         .ana_mode (ana_mode),
         .att      (att_code[p*WORD_W +: WORD_W]),
         .dac      (dac_code[p*DAC_W +: DAC_W]),
         .dac_en   (dac_en[p])
      );
   end

endmodule

// File: rtl/sctl_chk.sv
`timescale 1ns/1ps
module sctl_chk #(
   parameter int NUM_PATHS = 2,
   parameter int WORD_W    = 5,
   parameter int DAC_W     = 8,
   parameter int FRAME_W   = 56,
   parameter int CNT_W     = 6
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        csn_hi,
   input logic [FRAME_W-1:0]          shreg,
   input logic [CNT_W-1:0]            cnt,
   input logic                        commit,
   input logic [FRAME_W-1:0]          hold,
   input logic                        dig_mode,
   input logic                        ana_mode,
   input logic [NUM_PATHS*WORD_W-1:0] par_code,
   input logic [NUM_PATHS-1:0]        sel_a,
   input logic [NUM_PATHS-1:0]        sel_b,
   input logic [NUM_PATHS*WORD_W-1:0] att_code,
   input logic [NUM_PATHS*DAC_W-1:0]  dac_code,
   input logic [NUM_PATHS-1:0]        dac_en
);

   // R9
   hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hold) |-> $past(commit));

   // R9
   commit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> cnt == CNT_W'(FRAME_W));

   // R3
   commit_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> hold == $past(shreg));

   // R2
   shift_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(shreg) |-> !$past(csn_hi));

   // R2
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csn_hi |=> cnt == '0);

   // R6
   att_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(hold) && $stable(par_code) && $stable(sel_a) &&
       $stable(sel_b) && $stable(dig_mode)) |-> $stable(att_code));

   // R8
   dac_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ana_mode |-> (dac_en == '0 && dac_code == '0));

endmodule

bind atten_state_ctrl sctl_chk #(
   .NUM_PATHS (NUM_PATHS),
   .WORD_W    (WORD_W),
   .DAC_W     (DAC_W),
   .FRAME_W   (FRAME_W),
   .CNT_W     (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .csn_hi   (csn_hi),
   .shreg    (shreg),
   .cnt      (bit_cnt),
   .commit   (commit),
   .hold     (hold_q),
   .dig_mode (dig_mode),
   .ana_mode (ana_mode),
   .par_code (par_code),
   .sel_a    (sel_a),
   .sel_b    (sel_b),
   .att_code (att_code),
   .dac_code (dac_code),
   .dac_en   (dac_en)
);

// File: tb/sim_atten_state_ctrl.sv
`timescale 1ns/1ps
module sim_atten_state_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_csn = 1'b1;
   logic        dig_mode = 1'b1, ana_mode = 1'b1;
   logic [9:0]  par_code = '0;
   logic [1:0]  sel_a = '0, sel_b = '0;
   wire  [9:0]  att_code;
   wire  [15:0] dac_code;
   wire  [1:0]  dac_en;

   int          checks = 0, errors = 0;
   logic [55:0] hold_m = '0;
   logic        pend_en = 1'b0;
   logic [1:0]  pend_a = '0, pend_b = '0;

   always #10 clk = ~clk;

   atten_state_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_csn(ser_csn), .dig_mode(dig_mode), .ana_mode(ana_mode),
      .par_code(par_code), .sel_a(sel_a), .sel_b(sel_b),
      .att_code(att_code), .dac_code(dac_code), .dac_en(dac_en)
   );

   // frame layout of R4/R5
   function automatic logic [63:0] pack(
      logic [7:0] d1, logic [4:0] a1, logic [4:0] a2, logic [4:0] a3, logic [4:0] a4,
      logic [7:0] d2, logic [4:0] b1, logic [4:0] b2, logic [4:0] b3, logic [4:0] b4);
      return {8'h00, b4, b3, b2, b1, d2, a4, a3, a2, a1, d1};
   endfunction

   function automatic logic [4:0] m_att(int p);
      int idx;
      if (!dig_mode) return par_code[p*5 +: 5];
      idx = {sel_b[p], sel_a[p]};
      return hold_m[p*28 + 8 + idx*5 +: 5];
   endfunction

   function automatic logic [7:0] m_dac(int p);
      return ana_mode ? hold_m[p*28 +: 8] : 8'h00;
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_outputs(string tag);
      for (int p = 0; p < 2; p++) begin
         check_val({tag, " att"}, 32'(att_code[p*5 +: 5]), 32'(m_att(p)));
         check_val({tag, " dac"}, 32'(dac_code[p*8 +: 8]), 32'(m_dac(p)));
         check_val({tag, " dac_en"}, 32'(dac_en[p]), 32'(ana_mode));
      end
   endtask

   task automatic send_frame(logic [63:0] bits, int nbits, int half, bit exact);
      ser_csn = 1'b0;
      tick(2);
      for (int i = nbits - 1; i >= 0; i--) begin
         ser_clk = 1'b0; ser_dat = bits[i];
         tick(half);
         ser_clk = 1'b1;
         tick(half);
      end
      ser_clk = 1'b0;
      tick(half);
      ser_csn = 1'b1;
      if (pend_en) begin
         sel_a = pend_a; sel_b = pend_b; pend_en = 1'b0;
      end
      if (exact) begin
         tick(2);
         check_outputs("R3 before commit");
      end
      if (nbits == 56) hold_m = bits[55:0];
      if (exact) begin
         tick(1);
         check_outputs("R3 at commit");
         tick(2);
      end else begin
         tick(4);
      end
   endtask

   initial begin
      logic [63:0] f;
      logic [4:0]  exp1 [4];
      logic [4:0]  exp2 [4];
      void'($urandom(32'd20517));
      tick(3);
      rst_n = 1'b1;
      tick(2);

      // R1 reset state
      check_val("R1 att", 32'(att_code), 32'h0);
      check_val("R1 dac", 32'(dac_code), 32'h0);
      check_val("R1 dac_en", 32'(dac_en), 32'h3);

      // R4 R5 R6 directed preset table
      f = pack(8'hA5, 5'd3, 5'd17, 5'd9, 5'd30, 8'h3C, 5'd5, 5'd12, 5'd31, 5'd22);
      send_frame(f, 56, 4, 1'b1);
      check_val("R4 path1 dac", 32'(dac_code[7:0]), 32'hA5);
      check_val("R5 path2 dac", 32'(dac_code[15:8]), 32'h3C);
      exp1 = '{5'd3, 5'd17, 5'd9, 5'd30};
      exp2 = '{5'd5, 5'd12, 5'd31, 5'd22};
      for (int c = 0; c < 4; c++) begin
         sel_a = {1'(c ^ 3), 1'(c)};
         sel_b = {1'((c ^ 3) >> 1), 1'(c >> 1)};
         tick(1);
         check_val("R4 R6 path1 preset", 32'(att_code[4:0]), 32'(exp1[c]));
         check_val("R5 R6 path2 preset", 32'(att_code[9:5]), 32'(exp2[3-c]));
      end

      // R7 parallel bypass
      dig_mode = 1'b0;
      par_code = 10'b10110_01001;
      tick(1);
      check_val("R7 path1 parallel", 32'(att_code[4:0]), 32'd9);
      check_val("R7 path2 parallel", 32'(att_code[9:5]), 32'd22);
      dig_mode = 1'b1;

      // R8 analog mode off
      ana_mode = 1'b0;
      tick(1);
      check_val("R8 dac off", 32'(dac_code), 32'h0);
      check_val("R8 en off", 32'(dac_en), 32'h0);
      ana_mode = 1'b1;

      // R9 wrong lengths leave the table alone
      sel_a = 2'b11; sel_b = 2'b11;
      send_frame({$urandom, $urandom}, 55, 3, 1'b0);
      check_outputs("R9 short frame");
      send_frame({$urandom, $urandom}, 57, 3, 1'b0);
      check_outputs("R9 long frame");
      check_val("R9 table kept", 32'(att_code), {22'h0, 5'd22, 5'd30});

      // R10 fastest serial rate
      send_frame({8'h00, $urandom, $urandom}, 56, 2, 1'b1);
      check_outputs("R10 fast frame");

      // same-cycle: select change together with commit
      pend_en = 1'b1; pend_a = 2'b01; pend_b = 2'b10;
      send_frame({$urandom, $urandom}, 56, 3, 1'b1);
      check_outputs("R3 R6 select with commit");

      // R2 R6 R7 R8 R9 random traffic
      for (int it = 0; it < 40; it++) begin
         int len, sel;
         sel = int'($urandom % 8);
         len = (sel == 0) ? 55 : (sel == 1) ? 57 : 56;
         dig_mode = 1'($urandom); ana_mode = 1'($urandom);
         par_code = 10'($urandom); sel_a = 2'($urandom); sel_b = 2'($urandom);
         send_frame({$urandom, $urandom}, len, 2 + int'($urandom % 4), 1'b0);
         check_outputs("R2 R9 random frame");
         for (int k = 0; k < 2; k++) begin
            dig_mode = 1'($urandom); ana_mode = 1'($urandom);
            par_code = 10'($urandom); sel_a = 2'($urandom); sel_b = 2'($urandom);
            tick(1);
            check_outputs("R6 R7 R8 random pins");
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #3000000;
      checks++;
      errors++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule